// File: doc/BRIEF.md
# SPI Cipher Transfer Port

This block is a byte-oriented SPI target that sits between a host microcontroller and an on-chip 128-bit block-cipher engine. The host opens a transaction by pulling chip select low. It then clocks in 32 bytes: first a 128-bit plaintext block, then a 128-bit key. When chip select returns high after exactly 256 bits, the port presents both words in parallel and issues a single-cycle start pulse to the engine.

When the engine reports completion, the port captures its 128-bit result. In a later transaction the host clocks out 16 bytes and receives that result on MISO. All three SPI inputs pass through two-flop synchronizers, and all logic runs on the system clock. SCK must therefore be several times slower than the system clock.

Top module: `spi_cipher_port`

## Requirements
- R1: While reset is asserted, and right after it is released, `blk_pt_o`, `blk_key_o` and `blk_start_o` are zero and `spi_miso` is low.
- R2: Bits are taken MSB first on rising SCK (mode 0). The first 128 bits of a frame, most significant byte first, appear on `blk_pt_o`. The next 128 bits appear on `blk_key_o`.
- R3: When chip select deasserts after exactly 256 bits, `blk_start_o` is high for exactly one system clock cycle. It goes high only while `spi_cs_n` is high.
- R4: A frame whose bit count is not 256 (for example 128, 255 or 257) gives no start pulse and leaves `blk_pt_o` and `blk_key_o` unchanged.
- R5: A read frame that starts before completion has been seen since the last start pulse returns all-zero bits on MISO.
- R6: After `blk_done_i` has been seen high, the next frame returns the 128-bit `blk_ct_i` value on MISO, MSB first. MISO changes on falling SCK so it is stable at each rising SCK.
- R7: The result is captured on the first cycle that `blk_done_i` is high. Later changes of `blk_ct_i` do not alter it, and it can be read more than once. A new start pulse discards it, so reads return zeros again until the next completion.
- R8: While chip select is deasserted, `spi_miso` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock from host (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, low when idle |
| blk_pt_o | output | 128 | Plaintext word for the cipher engine |
| blk_key_o | output | 128 | Key word for the cipher engine |
| blk_start_o | output | 1 | One-cycle start pulse to the engine |
| blk_done_i | input | 1 | Completion flag from the engine |
| blk_ct_i | input | 128 | Result word from the engine |

## Verification
The bench aims at the frame-length boundary: 255 and 257 bit frames sit on either side of a valid one. A port that counts loosely would start the engine on garbage, or shift the key by one bit. Reading before completion, and again after a new start, exposes a design that keeps a stale result or forgets to clear its ready state; that design would return an old ciphertext. Changing the engine result after completion catches a port that follows `blk_done_i` instead of capturing it. The bench samples MISO at each rising SCK, so a port that shifts on the wrong edge loses or duplicates the first bit.

// File: rtl/spi_cipher_pkg.sv
package spi_cipher_pkg;
  localparam int unsigned BLK_W   = 128;
  localparam int unsigned FRAME_W = 2 * BLK_W;
  localparam int unsigned SYNC_N  = 2;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rx_frame.sv
module spi_rx_frame #(
  parameter int unsigned BLK_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start_i,
  input  logic             frame_end_i,
  input  logic             bit_stb_i,
  input  logic             bit_val_i,
  output logic [BLK_W-1:0] pt_o,
  output logic [BLK_W-1:0] key_o,
  output logic             start_o
);
  localparam int unsigned FRAME_W = 2 * BLK_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BLK_W-1:0]   pt_q, pt_d, key_q, key_d;
  logic               start_q, start_d;

  always_comb begin
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    pt_d    = pt_q;
    key_d   = key_q;
    start_d = 1'b0;
    if (frame_start_i) begin
      cnt_d = '0;
    end else if (bit_stb_i) begin
      sh_d = {sh_q[FRAME_W-2:0], bit_val_i};
      if (cnt_q != CNT_OVER) cnt_d = cnt_q + 1'b1;
    end
    if (frame_end_i && (cnt_q == CNT_FULL)) begin
      pt_d    = sh_q[FRAME_W-1:BLK_W];
      key_d   = sh_q[BLK_W-1:0];
      start_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      pt_q    <= '0;
      key_q   <= '0;
      start_q <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      pt_q    <= pt_d;
      key_q   <= key_d;
      start_q <= start_d;
    end
  end

  assign pt_o    = pt_q;
  assign key_o   = key_q;
  assign start_o = start_q;
endmodule

// File: rtl/spi_tx_frame.sv
module spi_tx_frame #(
  parameter int unsigned BLK_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  input  logic [BLK_W-1:0] ct_i,
  input  logic             discard_i,
  input  logic             frame_start_i,
  input  logic             shift_stb_i,
  input  logic             cs_active_i,
  output logic             miso_o
);
  logic             ready_q, ready_d;
  logic [BLK_W-1:0] hold_q, hold_d;
  logic [BLK_W-1:0] sh_q, sh_d;

  always_comb begin
    ready_d = ready_q;
    hold_d  = hold_q;
    sh_d    = sh_q;
    if (discard_i) begin
      ready_d = 1'b0;
    end else if (done_i && !ready_q) begin
      ready_d = 1'b1;
      hold_d  = ct_i;
    end
    if (frame_start_i) begin
      sh_d = ready_q ? hold_q : '0;
    end else if (shift_stb_i) begin
      sh_d = {sh_q[BLK_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      hold_q  <= '0;
      sh_q    <= '0;
    end else begin
      ready_q <= ready_d;
      hold_q  <= hold_d;
      sh_q    <= sh_d;
    end
  end

  assign miso_o = cs_active_i & sh_q[BLK_W-1];
endmodule

// File: rtl/spi_cipher_port.sv
module spi_cipher_port
  import spi_cipher_pkg::*;
#(
  parameter int unsigned BW      = BLK_W,
  parameter int unsigned SYNC_ST = SYNC_N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic [BW-1:0] blk_pt_o,
  output logic [BW-1:0] blk_key_o,
  output logic          blk_start_o,
  input  logic          blk_done_i,
  input  logic [BW-1:0] blk_ct_i
);
  logic [2:0] raw_in, sync_out;
  logic       csn_s, sck_s, mosi_s;
  logic       csn_q, sck_q;
  logic       cs_fall, cs_rise, sck_rise, sck_fall;

  assign raw_in = {spi_cs_n, spi_sck, spi_mosi};

  spi_sync #(.W(3), .STAGES(SYNC_ST), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(sync_out)
  );

  assign {csn_s, sck_s, mosi_s} = sync_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      csn_q <= csn_s;
      sck_q <= sck_s;
    end
  end

  assign cs_fall  = ~csn_s &  csn_q;
  assign cs_rise  =  csn_s & ~csn_q;
  assign sck_rise = ~csn_s &  sck_s & ~sck_q;
  assign sck_fall = ~csn_s & ~sck_s &  sck_q;

  spi_rx_frame #(.BLK_W(BW)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .frame_start_i(cs_fall), .frame_end_i(cs_rise),
    .bit_stb_i(sck_rise), .bit_val_i(mosi_s),
    .pt_o(blk_pt_o), .key_o(blk_key_o), .start_o(blk_start_o)
  );

  spi_tx_frame #(.BLK_W(BW)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .done_i(blk_done_i), .ct_i(blk_ct_i), .discard_i(blk_start_o),
    .frame_start_i(cs_fall), .shift_stb_i(sck_fall),
    .cs_active_i(~csn_s), .miso_o(spi_miso)
  );
endmodule

// File: rtl/spi_cipher_port_chk.sv
module spi_cipher_port_chk #(
  parameter int unsigned BW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spi_cs_n,
  input logic          csn_s,
  input logic          cs_fall,
  input logic          spi_miso,
  input logic          blk_start_o,
  input logic          blk_done_i,
  input logic [BW-1:0] blk_pt_o,
  input logic [BW-1:0] blk_key_o
);
  logic seen_done_q, zero_frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_done_q  <= 1'b0;
      zero_frame_q <= 1'b1;
    end else begin
      if (blk_start_o) seen_done_q <= 1'b0;
      else if (blk_done_i) seen_done_q <= 1'b1;
      if (cs_fall) zero_frame_q <= !seen_done_q;
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start_o |=> !blk_start_o);  // R3
  AST_START_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start_o |-> spi_cs_n);  // R3
  AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_start_o |-> ($stable(blk_pt_o) && $stable(blk_key_o)));  // R4
  AST_MISO_ZERO_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_frame_q && !cs_fall) |-> !spi_miso);  // R5
  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |-> !spi_miso);  // R8
endmodule

bind spi_cipher_port spi_cipher_port_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .csn_s(csn_s),
  .cs_fall(cs_fall), .spi_miso(spi_miso), .blk_start_o(blk_start_o),
  .blk_done_i(blk_done_i), .blk_pt_o(blk_pt_o), .blk_key_o(blk_key_o)
);

// File: tb/test_spi_cipher_port.sv
module test_spi_cipher_port;
  localparam int HALF = 8;
  // each vector: {plaintext, key, result}
  localparam logic [383:0] VEC [3] = '{
    {128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
     128'h69c4e0d86a7b0430d8cdb78070b4c55a},
    {128'h80000000000000000000000000000001, 128'hffffffffffffffffffffffffffffffff,
     128'h0123456789abcdeffedcba9876543210},
    {128'hdeadbeefcafef00d5a5aa5a5c3c33c3c, 128'h13579bdf2468ace0f0e1d2c3b4a59687,
     128'h8000000000000000000000000000ffff}
  };

  logic         clk, rst_n, sck, cs_n, mosi, miso, start, done;
  logic [127:0] pt, key, ct;
  int total = 0, bad = 0, starts = 0;
  bit finished = 0;

  spi_cipher_port i_spi_cipher_port (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .blk_pt_o(pt), .blk_key_o(key), .blk_start_o(start),
    .blk_done_i(done), .blk_ct_i(ct)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) if (start) starts++;

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic xfer(input int nbits, input logic [255:0] tx, output logic [255:0] rx);
    rx = '0;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 256) ? tx[255-i] : 1'b1;
      wait_clk(HALF);
      rx = {rx[254:0], miso};
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    mosi = 1'b0;
    wait_clk(20);
  endtask

  task automatic complete(input logic [127:0] res);
    ct = res; done = 1'b1;
    wait_clk(2);
    done = 1'b0; ct = ~res;  // later change must not leak out (R7)
    wait_clk(2);
  endtask

  initial begin
    logic [255:0] rx;
    logic [127:0] p, k, c;
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; mosi = 1'b0; done = 1'b0; ct = '0;
    wait_clk(4);
    check("R1 pt", {128'd0, pt}, 256'd0);
    check("R1 key", {128'd0, key}, 256'd0);
    check("R1 start/miso", {254'd0, start, miso}, 256'd0);
    rst_n = 1'b1;
    wait_clk(4);
    check("R1 after release", {254'd0, start, miso}, 256'd0);

    // read before any completion, also a 128-bit frame that must not start
    starts = 0;
    xfer(128, '0, rx);
    check("R5 read before done", rx, 256'd0);
    check("R4 128-bit frame no start", 256'(starts), 256'd0);

    for (int v = 0; v < 3; v++) begin
      p = VEC[v][383:256]; k = VEC[v][255:128]; c = VEC[v][127:0];
      starts = 0;
      xfer(256, {p, k}, rx);
      check("R3 start pulse count", 256'(starts), 256'd1);
      check("R2 plaintext", {128'd0, pt}, {128'd0, p});
      check("R2 key", {128'd0, key}, {128'd0, k});
      xfer(128, '0, rx);
      check("R7 cleared by start, zeros", rx, 256'd0);
      complete(c);
      check("R8 miso idle with result held", {255'd0, miso}, 256'd0);
      xfer(128, '0, rx);
      check("R6 result readout", rx, {128'd0, c});
      xfer(128, '0, rx);
      check("R7 result reread after ct change", rx, {128'd0, c});
    end

    starts = 0;
    xfer(255, {256{1'b1}}, rx);
    check("R4 255-bit frame no start", 256'(starts), 256'd0);
    check("R4 pt held", {128'd0, pt}, {128'd0, VEC[2][383:256]});
    xfer(257, 256'h5a, rx);
    check("R4 257-bit frame no start", 256'(starts), 256'd0);
    check("R4 key held", {128'd0, key}, {128'd0, VEC[2][255:128]});
    check("R8 miso idle", {255'd0, miso}, 256'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1-timeout actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule